// File: doc/BRIEF.md
# Parallel PRBS Bit Error Checker

This block sits behind a 1:16 deserializer and measures the bit error rate of a link that carries a pseudo-random test pattern. Each clock it takes one received word, regenerates the matching slice of the pattern locally, and counts the positions where the two disagree. The software or test logic above it divides the error count by the checked-bit count to obtain the error rate.

The checker synchronizes on its own. While not locked it fills its reference history straight from the incoming bits. It then tries to predict the next word and declares lock once a whole word is predicted without error. After that the reference runs free, so line errors are counted instead of being copied into the reference. A burst of errors in one word is taken as loss of alignment: the checker drops lock and starts over. The transmitter may thin the pattern to a lower mark density. The checker follows that shaping while locked, but it can only acquire lock on the unshaped pattern.

Top module: `prbs_err_checker`

## Requirements
- R1: Pattern select codes 0..4 choose the recurrences b[n]=b[n-6]^b[n-7], b[n-7]^b[n-10], b[n-14]^b[n-15], b[n-18]^b[n-23] and b[n-28]^b[n-31]. Codes 5..7 act as code 4. Bit 15 of a word is the earliest bit in time.
- R2: While unlocked with density code 0, every valid word is loaded into the reference history. After two such words, a valid word that matches the prediction in all 16 bits sets `locked` at that clock edge. A word with any mismatch leaves `locked` low.
- R3: Density code 0 checks raw bits. Code 1 checks the AND of each raw bit with the raw bit before it. Codes 2 and 3 check the AND with the two raw bits before it. While unlocked under a nonzero density code, valid words change neither `locked` nor the counters.
- R4: For a valid word while locked, the number of bit positions in which the word differs from the expected shaped word is added to `err_count`. Words received while unlocked add nothing.
- R5: `err_count` saturates at its all-ones value and never wraps.
- R6: `bit_count` rises by 16 for each valid word received while locked.
- R7: A valid word with more than 4 mismatched bits while locked clears `locked` at that edge. Its errors and bits are still counted.
- R8: `cnt_clear` zeroes both counters at the next edge and takes priority over a word counted in the same cycle.
- R9: A cycle with `rx_valid` low changes neither `locked` nor the counters.
- R10: After reset, `locked` is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_sel | input | 3 | Pattern length select |
| dens_sel | input | 2 | Mark density select |
| rx_word | input | W (16) | Received word, bit 15 earliest |
| rx_valid | input | 1 | rx_word holds a word this cycle |
| cnt_clear | input | 1 | Zero both counters |
| locked | output | 1 | Reference aligned with the incoming stream |
| err_count | output | ERR_W (32) | Saturating count of mismatched bits |
| bit_count | output | BIT_W (48) | Count of checked bits |

## Verification
The bench targets the lock edge: the two seeding words must leave `locked` low and the third must raise it. A checker that compared too early, or one bit off in time, would either lock on a zero history or never lock at all. Each word with five errors must drop lock and still be counted. A design that used four as the limit, or that dropped the word, would show a wrong count or a spurious loss of lock. Saturation is driven past a reduced counter width, where a wrapping counter would read near zero. A clear that coincides with a counted word must yield zero. Unlocked shaped traffic must leave the checker idle, because seeding from AND-thinned bits would produce a false lock.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  // Longest recurrence needs 31 bits of past history.
  localparam int HIST_W = 31;

  typedef struct packed {
    logic [4:0] near;
    logic [4:0] far;
  } tap_t;

  function automatic tap_t taps_for(input logic [2:0] sel);
    tap_t t;
    case (sel)
      3'd0:    t = '{near: 5'd6,  far: 5'd7};
      3'd1:    t = '{near: 5'd7,  far: 5'd10};
      3'd2:    t = '{near: 5'd14, far: 5'd15};
      3'd3:    t = '{near: 5'd18, far: 5'd23};
      default: t = '{near: 5'd28, far: 5'd31};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
  import prbs_chk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [2:0]        pat_sel,
  input  logic [1:0]        dens_sel,
  output logic [W-1:0]      raw_word,
  output logic [W-1:0]      shaped_word
);
  localparam int SEQ_W = HIST_W + W;

  // seq[i] is the bit at time i-HIST_W; negative times come from history.
  logic [SEQ_W-1:0] seq;
  tap_t             tp;

  always_comb begin
    tp  = taps_for(pat_sel);
    seq = '0;
    for (int i = 0; i < HIST_W; i++) begin
      seq[i] = hist[HIST_W-1-i];
    end
    for (int j = 0; j < W; j++) begin
      seq[HIST_W+j] = seq[HIST_W+j-int'(tp.near)] ^ seq[HIST_W+j-int'(tp.far)];
    end
  end

  always_comb begin
    raw_word    = '0;
    shaped_word = '0;
    for (int j = 0; j < W; j++) begin
      raw_word[W-1-j] = seq[HIST_W+j];
      case (dens_sel)
        2'd0:    shaped_word[W-1-j] = seq[HIST_W+j];
        2'd1:    shaped_word[W-1-j] = seq[HIST_W+j] & seq[HIST_W+j-1];
        default: shaped_word[W-1-j] = seq[HIST_W+j] & seq[HIST_W+j-1] & seq[HIST_W+j-2];
      endcase
    end
  end

endmodule

// File: rtl/prbs_chk_popcnt.sv
module prbs_chk_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/prbs_chk_counters.sv
module prbs_chk_counters #(
  parameter int W     = 16,
  parameter int ERR_W = 32,
  parameter int BIT_W = 48,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add_en,
  input  logic [CW-1:0]    add_errs,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ERR_W:0] err_sum;

  assign err_sum = {1'b0, err_count} + (ERR_W+1)'(add_errs);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      err_count <= '0;
      bit_count <= '0;
    end else if (add_en) begin
      err_count <= err_sum[ERR_W] ? ERR_MAX : err_sum[ERR_W-1:0];
      bit_count <= bit_count + BIT_W'(W);
    end
  end
endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import prbs_chk_pkg::*;
#(
  parameter int W          = 16,
  parameter int ERR_W      = 32,
  parameter int BIT_W      = 48,
  parameter int LOSS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       pat_sel,
  input  logic [1:0]       dens_sel,
  input  logic [W-1:0]     rx_word,
  input  logic             rx_valid,
  input  logic             cnt_clear,
  output logic             locked,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count
);
  localparam int CW         = $clog2(W + 1);
  localparam int FILL_WORDS = (HIST_W + W - 1) / W;
  localparam int FILL_W     = $clog2(FILL_WORDS + 1);

  logic [HIST_W-1:0]   hist;
  logic [FILL_W-1:0]   fill;
  logic [W-1:0]        raw_word;
  logic [W-1:0]        shaped_word;
  logic [CW-1:0]       word_errs;
  logic [HIST_W+W-1:0] cat_rx;
  logic [HIST_W+W-1:0] cat_ref;
  logic                too_many;
  logic                add_en;

  prbs_chk_predict #(.W(W)) u_predict (
    .hist        (hist),
    .pat_sel     (pat_sel),
    .dens_sel    (dens_sel),
    .raw_word    (raw_word),
    .shaped_word (shaped_word)
  );

  prbs_chk_popcnt #(.W(W), .CW(CW)) u_popcnt (
    .bits  (rx_word ^ shaped_word),
    .count (word_errs)
  );

  assign cat_rx   = {hist, rx_word};
  assign cat_ref  = {hist, raw_word};
  assign too_many = word_errs > CW'(LOSS_LIMIT);
  assign add_en   = locked & rx_valid;

  // Lock control: seed from the line while hunting, free-run once aligned.
  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      fill   <= '0;
      hist   <= '0;
    end else if (rx_valid) begin
      if (locked) begin
        hist <= cat_ref[HIST_W-1:0];
        if (too_many) begin
          locked <= 1'b0;
          fill   <= '0;
        end
      end else if (dens_sel == 2'd0) begin
        hist <= cat_rx[HIST_W-1:0];
        if (fill < FILL_W'(FILL_WORDS)) begin
          fill <= fill + 1'b1;
        end else if (rx_word == raw_word) begin
          locked <= 1'b1;
        end
      end
    end
  end

  prbs_chk_counters #(.W(W), .ERR_W(ERR_W), .BIT_W(BIT_W), .CW(CW)) u_counters (
    .clk       (clk),
    .rst       (rst),
    .clear     (cnt_clear),
    .add_en    (add_en),
    .add_errs  (word_errs),
    .err_count (err_count),
    .bit_count (bit_count)
  );

endmodule

// File: rtl/prbs_err_checker_sva.sv
module prbs_err_checker_sva #(
  parameter int W     = 16,
  parameter int ERR_W = 32,
  parameter int BIT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       dens_sel,
  input logic             rx_valid,
  input logic             cnt_clear,
  input logic             locked,
  input logic [ERR_W-1:0] err_count,
  input logic [BIT_W-1:0] bit_count
);
  // Lock is only acquired on a valid word in unshaped mode.
  assert_lock_entry_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(rx_valid) && $past(dens_sel) == 2'd0));

  // Nothing is counted while unlocked.
  assert_unlocked_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(locked) && !$past(cnt_clear)) |-> ($stable(err_count) && $stable(bit_count)));

  // Error count never goes down except through a clear.
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(cnt_clear) |-> (err_count >= $past(err_count)));

  // Each counted word adds exactly one word of bits.
  assert_bit_step_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(locked) && $past(rx_valid) && !$past(cnt_clear))
      |-> (bit_count == $past(bit_count) + BIT_W'(W)));

  // Lock is lost only on a received word.
  assert_drop_on_word_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(rx_valid));

  // Clear wins.
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_clear) |-> (err_count == '0 && bit_count == '0));

  // Idle cycles change nothing.
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rx_valid) && !$past(cnt_clear))
      |-> ($stable(locked) && $stable(err_count) && $stable(bit_count)));

endmodule

bind prbs_err_checker prbs_err_checker_sva #(.W(W), .ERR_W(ERR_W), .BIT_W(BIT_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .dens_sel  (dens_sel),
  .rx_valid  (rx_valid),
  .cnt_clear (cnt_clear),
  .locked    (locked),
  .err_count (err_count),
  .bit_count (bit_count)
);

// File: tb/sim_prbs_err_checker.sv
module sim_prbs_err_checker;
  localparam int  ERR_W = 8;
  localparam int  BIT_W = 48;
  localparam longint EMAX = 255;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       pat_sel = '0;
  logic [1:0]       dens_sel = '0;
  logic [15:0]      rx_word = '0;
  logic             rx_valid = 1'b0;
  logic             cnt_clear = 1'b0;
  logic             locked;
  logic [ERR_W-1:0] err_count;
  logic [BIT_W-1:0] bit_count;

  always #4 clk = ~clk;

  prbs_err_checker #(.W(16), .ERR_W(ERR_W), .BIT_W(BIT_W), .LOSS_LIMIT(4)) u0 (
    .clk(clk), .rst(rst), .pat_sel(pat_sel), .dens_sel(dens_sel),
    .rx_word(rx_word), .rx_valid(rx_valid), .cnt_clear(cnt_clear),
    .locked(locked), .err_count(err_count), .bit_count(bit_count)
  );

  int        nchecks = 0;
  int        nerrs   = 0;
  bit        done    = 0;
  bit        m_locked;
  int        m_fill;
  longint    m_err;
  longint    m_bits;
  logic [30:0] g;

  function automatic int pop16(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  // R1: recurrence tap distances per pattern code
  function automatic int tap_a(int p);
    case (p) 0: return 6; 1: return 7; 2: return 14; 3: return 18; default: return 28; endcase
  endfunction
  function automatic int tap_b(int p);
    case (p) 0: return 7; 1: return 10; 2: return 15; 3: return 23; default: return 31; endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    nchecks++;
    if (act != exp) begin
      nerrs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Transmit-side model: one shift register, g[0] is the newest raw bit.
  task automatic gen_word(output logic [15:0] w);
    logic r, s;
    w = '0;
    for (int j = 0; j < 16; j++) begin
      r = g[tap_a(int'(pat_sel))-1] ^ g[tap_b(int'(pat_sel))-1];
      case (dens_sel)
        2'd0:    s = r;
        2'd1:    s = r & g[0];
        default: s = r & g[0] & g[1];
      endcase
      w[15-j] = s;
      g = {g[29:0], r};
    end
  endtask

  task automatic make_mask(int k, output logic [15:0] m);
    m = '0;
    while (pop16(m) < k) m[$urandom_range(15, 0)] = 1'b1;
  endtask

  task automatic send(bit v, int nerr, bit clr);
    logic [15:0] w, m;
    if (v) begin
      gen_word(w);
      make_mask(nerr, m);
      rx_word = w ^ m;
    end else begin
      rx_word = 16'($urandom);
    end
    rx_valid  = v;
    cnt_clear = clr;
    @(posedge clk);
    #2;
    if (v) begin
      if (m_locked) begin
        m_bits += 16;
        m_err  += nerr;
        if (m_err > EMAX) m_err = EMAX;
        if (nerr > 4) begin m_locked = 0; m_fill = 0; end
      end else if (dens_sel == 2'd0) begin
        if (m_fill < 2) m_fill++;
        else if (nerr == 0) m_locked = 1;
      end
    end
    if (clr) begin m_err = 0; m_bits = 0; end
    if (!v) begin
      chk("R9 locked", longint'(locked), longint'(m_locked));
      chk("R9 err", longint'(err_count), m_err);
    end else begin
      chk("R1/R2 locked", longint'(locked), longint'(m_locked));
      chk("R4 err", longint'(err_count), m_err);
      chk("R6 bits", longint'(bit_count), m_bits);
    end
    rx_valid  = 1'b0;
    cnt_clear = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_valid = 1'b0; cnt_clear = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    m_locked = 0; m_fill = 0; m_err = 0; m_bits = 0;
    g = 31'($urandom) | 31'h1;
  endtask

  task automatic acquire();
    dens_sel = 2'd0;
    send(1, 0, 0);
    send(1, 0, 0);
    chk("R2 no lock during seeding", longint'(locked), 0);
    send(1, 0, 0);
    chk("R2 lock after matching word", longint'(locked), 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    chk("R10 locked", longint'(locked), 0);
    chk("R10 err", longint'(err_count), 0);
    chk("R10 bits", longint'(bit_count), 0);

    // R1 every pattern, random traffic with density changes and clears
    for (int p = 0; p < 5; p++) begin
      pat_sel = 3'(p);
      do_reset();
      acquire();
      for (int i = 0; i < 150; i++) begin
        bit v;
        v = ($urandom_range(9, 0) < 8);
        if (!m_locked) dens_sel = 2'd0;
        else if ($urandom_range(7, 0) == 0) dens_sel = 2'($urandom_range(3, 0)); // R3
        send(v, m_locked ? int'($urandom_range(4, 0)) : 0, ($urandom_range(19, 0) == 0));
      end
      // R7 five errors lose lock but still count
      dens_sel = 2'd0;
      begin
        longint e0, b0;
        e0 = m_err; b0 = m_bits;
        send(1, 5, 0);
        chk("R7 lock lost", longint'(locked), 0);
        chk("R7 errors counted", longint'(err_count), (e0 + 5 > EMAX) ? EMAX : e0 + 5);
        chk("R7 bits counted", longint'(bit_count), b0 + 16);
      end
      acquire();
    end

    // R2 a corrupted compare word must not lock
    pat_sel = 3'd4;
    do_reset();
    dens_sel = 2'd0;
    send(1, 0, 0);
    send(1, 0, 0);
    send(1, 1, 0);
    chk("R2 mismatch keeps unlocked", longint'(locked), 0);
    chk("R4 unlocked adds nothing", longint'(err_count), 0);

    // R3 shaped traffic never synchronizes
    pat_sel = 3'd2;
    do_reset();
    dens_sel = 2'd1;
    for (int i = 0; i < 6; i++) send(1, 0, 0);
    chk("R3 no lock in shaped mode", longint'(locked), 0);
    chk("R3 bits unchanged", longint'(bit_count), 0);

    // R5 saturation
    pat_sel = 3'd1;
    do_reset();
    acquire();
    for (int i = 0; i < 70; i++) send(1, 4, 0);
    chk("R5 saturated", longint'(err_count), EMAX);
    chk("R5 still locked", longint'(locked), 1);

    // R8 clear beats same-cycle count
    send(1, 2, 1);
    chk("R8 err cleared", longint'(err_count), 0);
    chk("R8 bits cleared", longint'(bit_count), 0);
    send(1, 3, 0);
    chk("R8 counting resumes", longint'(err_count), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchecks++;
      nerrs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
      $finish;
    end
  end

endmodule